// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

This block is a real-time timer of the kind a processor keeps beside its control registers. It holds a free-running 32-bit count register and a 32-bit compare register. Software reads and writes both through a small register port that has a select line. The count register advances by one on every second clock. Logic that compares the two registers without pause sets a sticky timer-pending bit when they match. The only way to clear that bit is a write to the compare register.

The interrupt output merges the timer-pending bit with a performance-counter request that comes in on a pin. One shared mask bit gates both sources. No separate timer enable exists, so clearing the mask silences both sources together. The pending bit can always be read on its own output, whatever the mask holds. Software uses the unit by loading compare with a future count value, waiting for the interrupt, and writing compare again to acknowledge it and set the next deadline.

The reset input is asserted asynchronously and is released synchronously inside the block after two clock edges.

Top module: `cnt_cmp_timer`

## Requirements
- R1: While reset is held, count reads 0, compare reads 0xFFFFFFFF, the pending bit is 0 and the interrupt output is 0.
- R2: After a write to count, the written value reads back for two clocks and then grows by one every second clock. The write restarts the two-clock phase.
- R3: Count wraps from 0xFFFFFFFF to 0 and goes on counting.
- R4: On the clock after count and compare hold equal values, the pending bit reads 1. It stays 1 until compare is written, even after count has moved past compare.
- R5: A write to compare clears the pending bit on that clock, even when the written value equals count. The match is then judged again against the new compare value on the next clock.
- R6: If a compare write lands in the same clock as a match against the old compare value, the write wins and the pending bit is 0 afterwards.
- R7: The interrupt output equals (pending OR perf_irq) AND irq_mask, so with irq_mask at 0 neither source reaches it.
- R8: The pending output shows the pending bit whatever the value of irq_mask.
- R9: The read data shows count when reg_sel is 0 and compare when reg_sel is 1. A write goes to the register chosen by reg_sel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 count, 1 compare |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| perf_irq | input | 1 | Performance-counter interrupt request |
| irq_mask | input | 1 | Shared mask for the timer and performance-counter interrupts |
| tmr_pending | output | 1 | Timer pending bit |
| irq_out | output | 1 | Masked, combined interrupt request |

## Verification
The bench loads count and then samples it clock by clock. A design that counted every cycle, or that did not restart the phase on a write, would show the loaded value for one clock only. Writing compare with the value count currently holds catches a design that compared the written data combinationally or skipped the clear on an equal value, because the pending bit would not read 0 right after the write. A back-to-back sequence puts a compare write in the same clock as a live match; a design where set beats clear would leave the bit at 1. The mask cases drive the performance-counter request with pending low, which exposes an unmasked or timer-only gate.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  parameter int unsigned TMR_W = 32;

  typedef enum logic {
    SEL_COUNT   = 1'b0,
    SEL_COMPARE = 1'b1
  } tmr_sel_e;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         phase_q, phase_d;

  // Phase toggles each clock; count steps when phase is high.
  always_comb begin
    cnt_d   = cnt_q;
    phase_d = ~phase_q;
    if (load) begin
      cnt_d   = load_val;
      phase_d = 1'b0;
    end else if (phase_q) begin
      cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic         cmp_we,
  input  logic [W-1:0] cmp_wdata,
  output logic [W-1:0] cmp,
  output logic         pending
);
  logic [W-1:0] cmp_q, cmp_d;
  logic         pend_q, pend_d;
  logic         hit;

  assign hit = (cnt == cmp_q);

  // A compare write takes priority over a match in the same cycle.
  always_comb begin
    cmp_d  = cmp_q;
    pend_d = pend_q | hit;
    if (cmp_we) begin
      cmp_d  = cmp_wdata;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '1;
      pend_q <= 1'b0;
    end else begin
      cmp_q  <= cmp_d;
      pend_q <= pend_d;
    end
  end

  assign cmp     = cmp_q;
  assign pending = pend_q;
endmodule

// File: rtl/cnt_cmp_timer.sv
module cnt_cmp_timer
  import tmr_pkg::*;
#(
  parameter int unsigned W = TMR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_we,
  input  logic         reg_sel,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         perf_irq,
  input  logic         irq_mask,
  output logic         tmr_pending,
  output logic         irq_out
);
  tmr_sel_e     sel;
  logic         rst_sync_n;
  logic         wr_cnt, wr_cmp;
  logic [W-1:0] cnt_val, cmp_val;
  logic         pend;

  assign sel    = tmr_sel_e'(reg_sel);
  assign wr_cnt = reg_we && (sel == SEL_COUNT);
  assign wr_cmp = reg_we && (sel == SEL_COMPARE);

  tmr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tmr_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (wr_cnt),
    .load_val (reg_wdata),
    .cnt      (cnt_val)
  );

  tmr_match #(.W(W)) u_match (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cnt       (cnt_val),
    .cmp_we    (wr_cmp),
    .cmp_wdata (reg_wdata),
    .cmp       (cmp_val),
    .pending   (pend)
  );

  assign reg_rdata   = (sel == SEL_COMPARE) ? cmp_val : cnt_val;
  assign tmr_pending = pend;
  assign irq_out     = (pend | perf_irq) & irq_mask;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_cnt,
  input logic         wr_cmp,
  input logic [W-1:0] wdata,
  input logic [W-1:0] cnt,
  input logic [W-1:0] cmp,
  input logic         pending,
  input logic         irq_mask,
  input logic         irq_out
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cnt |=> (cnt == $past(cnt) || cnt == $past(cnt) + W'(1)));

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt == $past(wdata)));

  p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cmp && cnt == cmp) |=> pending);

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !wr_cmp) |=> pending);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmp |=> !pending);

  p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mask |-> !irq_out);
endmodule

bind cnt_cmp_timer tmr_checker #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .wr_cnt   (wr_cnt),
  .wr_cmp   (wr_cmp),
  .wdata    (reg_wdata),
  .cnt      (cnt_val),
  .cmp      (cmp_val),
  .pending  (pend),
  .irq_mask (irq_mask),
  .irq_out  (irq_out)
);

// File: tb/sim_cnt_cmp_timer.sv
`timescale 1ns/1ps
module sim_cnt_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic        reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        perf_irq;
  logic        irq_mask;
  logic        tmr_pending;
  logic        irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  cnt_cmp_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .perf_irq(perf_irq),
    .irq_mask(irq_mask), .tmr_pending(tmr_pending), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the write.
  task automatic wr(input logic sel, input logic [31:0] data);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0; reg_sel = 1'b0;
    #0.5;
  endtask

  task automatic step();
    @(negedge clk);
    #0.5;
  endtask

  task automatic t_reset();
    irq_mask = 1'b1;
    reg_sel = 1'b0; #0.5;
    check("R1 count", reg_rdata, 32'h0);
    reg_sel = 1'b1; #0.5;
    check("R1 compare", reg_rdata, 32'hFFFF_FFFF);
    reg_sel = 1'b0;
    check("R1 pending", {31'b0, tmr_pending}, 32'h0);
    check("R1 irq", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_rate();
    wr(1'b0, 32'd100);
    check("R2 after load", reg_rdata, 32'd100);
    step(); check("R2 hold", reg_rdata, 32'd100);
    step(); check("R2 step1", reg_rdata, 32'd101);
    step(); check("R2 hold2", reg_rdata, 32'd101);
    step(); check("R2 step2", reg_rdata, 32'd102);
  endtask

  task automatic t_wrap();
    wr(1'b0, 32'hFFFF_FFFF);
    step(); check("R3 before wrap", reg_rdata, 32'hFFFF_FFFF);
    step(); check("R3 wrap", reg_rdata, 32'h0);
    step(); step(); check("R3 after wrap", reg_rdata, 32'h1);
  endtask

  task automatic t_match();
    wr(1'b1, 32'd503);
    wr(1'b0, 32'd500);
    for (int i = 0; i < 6; i++) step();
    check("R4 count at match", reg_rdata, 32'd503);
    check("R4 not yet pending", {31'b0, tmr_pending}, 32'h0);
    step(); check("R4 pending set", {31'b0, tmr_pending}, 32'h1);
    for (int i = 0; i < 6; i++) step();
    check("R4 sticky", {31'b0, tmr_pending}, 32'h1);
  endtask

  task automatic t_mask();
    perf_irq = 1'b0; irq_mask = 1'b0; #0.5;
    check("R7 masked timer", {31'b0, irq_out}, 32'h0);
    check("R8 pending visible masked", {31'b0, tmr_pending}, 32'h1);
    irq_mask = 1'b1; #0.5;
    check("R7 unmasked timer", {31'b0, irq_out}, 32'h1);
  endtask

  task automatic t_clear_equal();
    wr(1'b0, 32'd1000);
    wr(1'b1, 32'd1000);
    check("R5 cleared on equal write", {31'b0, tmr_pending}, 32'h0);
    step(); check("R5 rematch next cycle", {31'b0, tmr_pending}, 32'h1);
  endtask

  task automatic t_conflict();
    wr(1'b1, 32'd2000);
    wr(1'b0, 32'd2000);
    step(); check("R6 match set", {31'b0, tmr_pending}, 32'h1);
    wr(1'b1, 32'd5000);
    check("R6 write wins", {31'b0, tmr_pending}, 32'h0);
    step(); check("R6 stays clear", {31'b0, tmr_pending}, 32'h0);
    reg_sel = 1'b1; #0.5;
    check("R9 compare readback", reg_rdata, 32'd5000);
    reg_sel = 1'b0; #0.5;
    check("R9 count readback", reg_rdata, 32'd2001);
  endtask

  task automatic t_perf();
    perf_irq = 1'b1; irq_mask = 1'b1; #0.5;
    check("R7 perf unmasked", {31'b0, irq_out}, 32'h1);
    irq_mask = 1'b0; #0.5;
    check("R7 perf masked", {31'b0, irq_out}, 32'h0);
    check("R8 pending low", {31'b0, tmr_pending}, 32'h0);
    perf_irq = 1'b0; irq_mask = 1'b1; #0.5;
    check("R7 idle", {31'b0, irq_out}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    perf_irq = 1'b0; irq_mask = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_rate();
    t_wrap();
    t_match();
    t_mask();
    t_clear_equal();
    t_conflict();
    t_perf();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule